// File: doc/BRIEF.md
# Accumulator CPU Register File with Operand Decode

This block holds the architectural registers of a small 8-bit accumulator processor. Eight byte registers form four 16-bit pairs, each pair high:low: A:F, B:C, D:E and H:L. A 16-bit stack pointer and a 16-bit program counter sit beside them. The execution stage never names a register directly. It hands the block the raw operand field from the instruction: a 3-bit byte selector, or a 2-bit word selector with a group number. The block resolves that field into read data or a register update.

A byte selector value of 6 names the byte in memory whose address is in HL. The block turns that operand into a request on its memory port. The word group decides what the top selector value means, and one group steps HL after each access. The flag byte keeps only its upper nibble. A separate masked flag port lets the ALU change individual flags.

The memory port uses a valid/ready handshake. The block holds `mem_req_valid`, `mem_req_write`, `mem_req_addr` and `mem_req_wdata` steady for as long as the operand stays presented. A write completes in the cycle where `mem_req_ready` is high. A read completes in the cycle where both `mem_req_ready` and `mem_rsp_valid` are high. While a memory operand is waiting, `rd_valid` or `wr_ack` stays low and the caller must hold its inputs.

Top module: `opnd_regfile`

## Requirements
- R1: After reset every register, SP and PC read as zero and `flags` is 0000.
- R2: A byte selector on `rd_sel`/`wr_sel` (wide=0) maps 0,1,2,3,4,5,7 to B,C,D,E,H,L,A. Byte reads return the register in `rd_data[7:0]` with bits 15:8 zero. A byte write is visible in the matching half of a pair read.
- R3: `flags` is {Z,N,H,C}, taken from F bits 7,6,5,4. The low nibble of F always reads zero, including after a 16-bit write to AF.
- R4: `flg_we` bit i writes `flg_val` bit i into the flag in position i of `flags`. Flags whose mask bit is clear keep their value. An explicit write to AF in the same cycle overrides the flag port.
- R5: A word access (wide=1) uses sel[1:0]. In group 1 it maps 0..3 to BC, DE, HL, SP. Group value 0 behaves as group 1.
- R6: In group 3, word selectors 0..3 map to BC, DE, HL, AF.
- R7: In group 2, a word read with selector 2 or 3 returns the current HL. At that clock edge HL becomes HL+1 for selector 2 or HL-1 for selector 3, wrapping modulo 65536.
- R8: In group 2, a word write with selector 2 or 3 leaves HL equal to the written value plus 1 or minus 1 respectively, wrapping.
- R9: If a write to H, L or HL is accepted in the same cycle as a stepping read, the step is dropped and the explicit write wins. A write to any other register does not cancel the step.
- R10: A byte read with selector 6 raises `mem_req_valid` with `mem_req_write`=0 and `mem_req_addr`=HL. `rd_valid` rises only when `mem_req_ready` and `mem_rsp_valid` are both high, and `rd_data` is then {8'h00, `mem_rsp_data`}.
- R11: A byte write with selector 6 raises a memory write of `wr_data[7:0]` at address HL. `wr_ack` is high only when `mem_req_ready` is high, and no register changes.
- R12: When a selector-6 read and a selector-6 write are presented together, the write takes the memory port and `rd_valid` stays low.
- R13: `pc_we` loads `pc_wdata` into PC at the clock edge, and `pc` shows the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read operand presented |
| rd_wide | input | 1 | 1 = word selector, 0 = byte selector |
| rd_sel | input | 3 | Read selector field |
| rd_grp | input | 2 | Word group for reads (0/1, 2, 3) |
| rd_data | output | 16 | Read result |
| rd_valid | output | 1 | Read result is valid this cycle |
| wr_en | input | 1 | Write operand presented |
| wr_wide | input | 1 | 1 = word selector, 0 = byte selector |
| wr_sel | input | 3 | Write selector field |
| wr_grp | input | 2 | Word group for writes |
| wr_data | input | 16 | Write value |
| wr_ack | output | 1 | Write accepted this cycle |
| flg_we | input | 4 | Per-flag write mask {Z,N,H,C} |
| flg_val | input | 4 | Flag values {Z,N,H,C} |
| flags | output | 4 | Current flags {Z,N,H,C} |
| pc_we | input | 1 | Program counter load |
| pc_wdata | input | 16 | Program counter load value |
| pc | output | 16 | Program counter |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 16 | Memory address (HL) |
| mem_req_wdata | output | 8 | Memory write byte |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 8 | Read response byte |

## Verification
The bound checker watches several rules on every cycle. The low flag nibble must read as zero whenever AF is read, and a stalled memory write must never be acknowledged. A contended read must never complete, HL must advance after an uncontended post-increment read, and a PC load must land. Only the bench scenarios can show the full selector-to-register mapping across all three groups and the HL wrap at both ends. They also show that a stepping read loses to an explicit H/L write but not to a write elsewhere, and that masked flag updates leave unmasked flags alone.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int NUM_BYTES = 8;
  localparam int IDX_W     = $clog2(NUM_BYTES);

  // storage slots; the byte selector value equals the slot for B..L and A
  localparam logic [IDX_W-1:0] IDX_B = 3'd0;
  localparam logic [IDX_W-1:0] IDX_C = 3'd1;
  localparam logic [IDX_W-1:0] IDX_D = 3'd2;
  localparam logic [IDX_W-1:0] IDX_E = 3'd3;
  localparam logic [IDX_W-1:0] IDX_H = 3'd4;
  localparam logic [IDX_W-1:0] IDX_L = 3'd5;
  localparam logic [IDX_W-1:0] IDX_F = 3'd6;
  localparam logic [IDX_W-1:0] IDX_A = 3'd7;

  localparam logic [2:0] SEL_INDIRECT = 3'd6;
  localparam int         NUM_FLAGS    = 4;

  typedef enum logic [2:0] {TGT_NONE, TGT_BYTE, TGT_MEM, TGT_PAIR, TGT_SP} tgt_e;
  typedef enum logic [1:0] {STEP_NONE, STEP_INC, STEP_DEC} step_e;

  typedef struct packed {
    tgt_e             tgt;
    logic [IDX_W-1:0] hi;
    logic [IDX_W-1:0] lo;
    step_e            step;
  } dec_t;
endpackage

// File: rtl/rf_sel_decode.sv
module rf_sel_decode
  import rf_pkg::*;
(
  input  logic       en,
  input  logic       wide,
  input  logic [2:0] sel,
  input  logic [1:0] grp,
  output dec_t       dec
);
  always_comb begin
    dec.tgt  = TGT_NONE;
    dec.hi   = IDX_B;
    dec.lo   = IDX_B;
    dec.step = STEP_NONE;
    if (en) begin
      if (!wide) begin
        if (sel == SEL_INDIRECT) begin
          dec.tgt = TGT_MEM;
        end else begin
          dec.tgt = TGT_BYTE;
          dec.lo  = sel;
        end
      end else begin
        dec.tgt = TGT_PAIR;
        unique case (sel[1:0])
          2'd0: begin dec.hi = IDX_B; dec.lo = IDX_C; end
          2'd1: begin dec.hi = IDX_D; dec.lo = IDX_E; end
          2'd2: begin
            dec.hi = IDX_H; dec.lo = IDX_L;
            if (grp == 2'd2) dec.step = STEP_INC;
          end
          default: begin
            unique case (grp)
              2'd2: begin dec.hi = IDX_H; dec.lo = IDX_L; dec.step = STEP_DEC; end
              2'd3: begin dec.hi = IDX_A; dec.lo = IDX_F; end
              default: dec.tgt = TGT_SP;
            endcase
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/rf_store.sv
module rf_store
  import rf_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
)(
  input  logic                          clk,
  input  logic                          rst_n,
  input  dec_t                          wr_dec,
  input  logic                          wr_go,
  input  logic [AW-1:0]                 wr_data,
  input  step_e                         rd_step,
  input  logic                          rd_go,
  input  logic [NUM_FLAGS-1:0]          flg_we,
  input  logic [NUM_FLAGS-1:0]          flg_val,
  input  logic                          pc_we,
  input  logic [AW-1:0]                 pc_wdata,
  output logic [NUM_BYTES-1:0][DW-1:0]  regs_q,
  output logic [AW-1:0]                 sp_q,
  output logic [AW-1:0]                 pc_q
);
  logic [NUM_BYTES-1:0][DW-1:0] regs_n;
  logic [AW-1:0]                sp_n;
  logic [AW-1:0]                hl_cur;
  logic                         wr_hits_hl;

  function automatic logic [AW-1:0] stepped(input logic [AW-1:0] v, input step_e s);
    unique case (s)
      STEP_INC: stepped = v + AW'(1);
      STEP_DEC: stepped = v - AW'(1);
      default:  stepped = v;
    endcase
  endfunction

  assign hl_cur = {regs_q[IDX_H], regs_q[IDX_L]};

  always_comb begin
    wr_hits_hl = 1'b0;
    if (wr_go) begin
      if (wr_dec.tgt == TGT_BYTE && (wr_dec.lo == IDX_H || wr_dec.lo == IDX_L))
        wr_hits_hl = 1'b1;
      if (wr_dec.tgt == TGT_PAIR && wr_dec.hi == IDX_H)
        wr_hits_hl = 1'b1;
    end
  end

  always_comb begin
    regs_n = regs_q;
    sp_n   = sp_q;
    // side effect of a stepping read, dropped when the write claims HL
    if (rd_go && rd_step != STEP_NONE && !wr_hits_hl)
      {regs_n[IDX_H], regs_n[IDX_L]} = stepped(hl_cur, rd_step);
    // masked flag port
    for (int f = 0; f < NUM_FLAGS; f++) begin
      if (flg_we[f]) regs_n[IDX_F][DW-NUM_FLAGS+f] = flg_val[f];
    end
    // explicit write has the last word
    if (wr_go) begin
      unique case (wr_dec.tgt)
        TGT_BYTE: regs_n[wr_dec.lo] = wr_data[DW-1:0];
        TGT_PAIR: begin
          if (wr_dec.step != STEP_NONE) begin
            {regs_n[IDX_H], regs_n[IDX_L]} = stepped(wr_data, wr_dec.step);
          end else begin
            regs_n[wr_dec.hi] = wr_data[AW-1:DW];
            regs_n[wr_dec.lo] = wr_data[DW-1:0];
          end
        end
        TGT_SP:  sp_n = wr_data;
        default: ;
      endcase
    end
    regs_n[IDX_F][DW-NUM_FLAGS-1:0] = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs_q <= '0;
      sp_q   <= '0;
      pc_q   <= '0;
    end else begin
      regs_q <= regs_n;
      sp_q   <= sp_n;
      if (pc_we) pc_q <= pc_wdata;
    end
  end
endmodule

// File: rtl/rf_mem_port.sv
module rf_mem_port #(
  parameter int DW = 8,
  localparam int AW = 2 * DW
)(
  input  logic          rd_mem,
  input  logic          wr_mem,
  input  logic [AW-1:0] hl,
  input  logic [DW-1:0] wbyte,
  input  logic          req_ready,
  input  logic          rsp_valid,
  output logic          req_valid,
  output logic          req_write,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  output logic          rd_done,
  output logic          wr_done
);
  // a write owns the port whenever one is presented
  assign req_valid = rd_mem | wr_mem;
  assign req_write = wr_mem;
  assign req_addr  = hl;
  assign req_wdata = wbyte;
  assign wr_done   = wr_mem & req_ready;
  assign rd_done   = rd_mem & ~wr_mem & req_ready & rsp_valid;
endmodule

// File: rtl/opnd_regfile.sv
module opnd_regfile
  import rf_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_en,
  input  logic                 rd_wide,
  input  logic [2:0]           rd_sel,
  input  logic [1:0]           rd_grp,
  output logic [AW-1:0]        rd_data,
  output logic                 rd_valid,
  input  logic                 wr_en,
  input  logic                 wr_wide,
  input  logic [2:0]           wr_sel,
  input  logic [1:0]           wr_grp,
  input  logic [AW-1:0]        wr_data,
  output logic                 wr_ack,
  input  logic [NUM_FLAGS-1:0] flg_we,
  input  logic [NUM_FLAGS-1:0] flg_val,
  output logic [NUM_FLAGS-1:0] flags,
  input  logic                 pc_we,
  input  logic [AW-1:0]        pc_wdata,
  output logic [AW-1:0]        pc,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic                 mem_req_write,
  output logic [AW-1:0]        mem_req_addr,
  output logic [DW-1:0]        mem_req_wdata,
  input  logic                 mem_rsp_valid,
  input  logic [DW-1:0]        mem_rsp_data
);
  dec_t                         rd_dec, wr_dec;
  logic [NUM_BYTES-1:0][DW-1:0] regs_q;
  logic [AW-1:0]                sp_q;
  logic [AW-1:0]                hl_q;
  logic                         rd_mem, wr_mem, rd_done, wr_done, wr_go;

  rf_sel_decode u_rd_dec (.en(rd_en), .wide(rd_wide), .sel(rd_sel), .grp(rd_grp), .dec(rd_dec));
  rf_sel_decode u_wr_dec (.en(wr_en), .wide(wr_wide), .sel(wr_sel), .grp(wr_grp), .dec(wr_dec));

  assign rd_mem = (rd_dec.tgt == TGT_MEM);
  assign wr_mem = (wr_dec.tgt == TGT_MEM);
  assign hl_q   = {regs_q[IDX_H], regs_q[IDX_L]};

  rf_mem_port #(.DW(DW)) u_mem (
    .rd_mem(rd_mem), .wr_mem(wr_mem), .hl(hl_q), .wbyte(wr_data[DW-1:0]),
    .req_ready(mem_req_ready), .rsp_valid(mem_rsp_valid),
    .req_valid(mem_req_valid), .req_write(mem_req_write),
    .req_addr(mem_req_addr), .req_wdata(mem_req_wdata),
    .rd_done(rd_done), .wr_done(wr_done)
  );

  assign rd_valid = rd_en & (rd_mem ? rd_done : 1'b1);
  assign wr_ack   = wr_en & (wr_mem ? wr_done : 1'b1);
  assign wr_go    = wr_ack & ~wr_mem;

  rf_store #(.DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_dec(wr_dec), .wr_go(wr_go), .wr_data(wr_data),
    .rd_step(rd_dec.step), .rd_go(rd_en),
    .flg_we(flg_we), .flg_val(flg_val),
    .pc_we(pc_we), .pc_wdata(pc_wdata),
    .regs_q(regs_q), .sp_q(sp_q), .pc_q(pc)
  );

  always_comb begin
    unique case (rd_dec.tgt)
      TGT_BYTE: rd_data = {{DW{1'b0}}, regs_q[rd_dec.lo]};
      TGT_MEM:  rd_data = {{DW{1'b0}}, mem_rsp_data};
      TGT_PAIR: rd_data = {regs_q[rd_dec.hi], regs_q[rd_dec.lo]};
      TGT_SP:   rd_data = sp_q;
      default:  rd_data = '0;
    endcase
  end

  assign flags = regs_q[IDX_F][DW-1:DW-NUM_FLAGS];
endmodule

// File: rtl/opnd_regfile_chk.sv
module opnd_regfile_chk #(
  parameter int DW = 8,
  localparam int AW = 2 * DW
)(
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en,
  input logic          rd_wide,
  input logic [2:0]    rd_sel,
  input logic [1:0]    rd_grp,
  input logic [AW-1:0] rd_data,
  input logic          rd_valid,
  input logic          wr_en,
  input logic          wr_ack,
  input logic          pc_we,
  input logic [AW-1:0] pc_wdata,
  input logic [AW-1:0] pc,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_write,
  input logic [AW-1:0] hl
);
  logic rd_is_af, rd_is_ind, rd_is_inc;
  assign rd_is_af  = rd_en && rd_wide && rd_grp == 2'd3 && rd_sel[1:0] == 2'd3;
  assign rd_is_ind = rd_en && !rd_wide && rd_sel == 3'd6;
  assign rd_is_inc = rd_en && rd_wide && rd_grp == 2'd2 && rd_sel[1:0] == 2'd2;

  assert_flag_low_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_is_af |-> rd_data[DW-5:0] == '0);

  assert_hl_post_inc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_is_inc && !wr_en |=> hl == $past(hl) + AW'(1));

  assert_mem_write_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write && !mem_req_ready |-> !wr_ack);

  assert_write_owns_port_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_is_ind && mem_req_write |-> !rd_valid);

  assert_pc_load_R13: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |=> pc == $past(pc_wdata));
endmodule

bind opnd_regfile opnd_regfile_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_wide(rd_wide), .rd_sel(rd_sel),
  .rd_grp(rd_grp), .rd_data(rd_data), .rd_valid(rd_valid), .wr_en(wr_en),
  .wr_ack(wr_ack), .pc_we(pc_we), .pc_wdata(pc_wdata), .pc(pc),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .hl(hl_q)
);

// File: tb/sim_opnd_regfile.sv
`timescale 1ns/1ps
module sim_opnd_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 0, rd_wide = 0, wr_en = 0, wr_wide = 0, pc_we = 0;
  logic [2:0]  rd_sel = 0, wr_sel = 0;
  logic [1:0]  rd_grp = 0, wr_grp = 0;
  logic [15:0] wr_data = 0, pc_wdata = 0;
  logic [3:0]  flg_we = 0, flg_val = 0;
  logic        mem_req_ready = 0, mem_rsp_valid = 0;
  logic [7:0]  mem_rsp_data = 0;
  logic [15:0] rd_data, pc, mem_req_addr;
  logic        rd_valid, wr_ack, mem_req_valid, mem_req_write;
  logic [3:0]  flags;
  logic [7:0]  mem_req_wdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  opnd_regfile u0 (
    .clk(clk), .rst_n(rst_n),
    .rd_en(rd_en), .rd_wide(rd_wide), .rd_sel(rd_sel), .rd_grp(rd_grp),
    .rd_data(rd_data), .rd_valid(rd_valid),
    .wr_en(wr_en), .wr_wide(wr_wide), .wr_sel(wr_sel), .wr_grp(wr_grp),
    .wr_data(wr_data), .wr_ack(wr_ack),
    .flg_we(flg_we), .flg_val(flg_val), .flags(flags),
    .pc_we(pc_we), .pc_wdata(pc_wdata), .pc(pc),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // one-cycle read: returns the value seen before the edge
  task automatic rd(input logic w, input logic [2:0] s, input logic [1:0] g, output logic [15:0] d);
    @(negedge clk);
    rd_en = 1; rd_wide = w; rd_sel = s; rd_grp = g;
    #1 d = rd_data;
    @(posedge clk);
    #1 rd_en = 0;
  endtask

  task automatic wr(input logic w, input logic [2:0] s, input logic [1:0] g, input logic [15:0] v);
    @(negedge clk);
    wr_en = 1; wr_wide = w; wr_sel = s; wr_grp = g; wr_data = v;
    @(posedge clk);
    #1 wr_en = 0;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    chk("R1 pc", pc, 16'h0000);
    chk("R1 flags", {12'h0, flags}, 16'h0000);
    rd(1, 3, 3, d); chk("R1 AF", d, 16'h0000);
    rd(1, 3, 1, d); chk("R1 SP", d, 16'h0000);
    rd(1, 2, 1, d); chk("R1 HL", d, 16'h0000);
  endtask

  task automatic t_bytes;
    logic [15:0] d;
    for (int i = 0; i < 8; i++) if (i != 6) wr(0, 3'(i), 0, 16'h0010 + 16'(i));
    for (int i = 0; i < 8; i++) if (i != 6) begin
      rd(0, 3'(i), 0, d); chk("R2 byte read", d, 16'h0010 + 16'(i));
    end
    rd(1, 0, 1, d); chk("R2 BC pair", d, 16'h1011);
    rd(1, 1, 1, d); chk("R2 DE pair", d, 16'h1213);
    rd(1, 2, 1, d); chk("R2 HL pair", d, 16'h1415);
    rd(1, 3, 3, d); chk("R6 AF pair", d, 16'h1700);
  endtask

  task automatic t_flags;
    logic [15:0] d;
    wr(1, 3, 3, 16'hABCD);
    rd(1, 3, 3, d); chk("R3 AF low nibble", d, 16'hABC0);
    chk("R3 flags", {12'h0, flags}, 16'h000C);
    @(negedge clk); flg_we = 4'b0101; flg_val = 4'b0001;
    @(posedge clk); #1 flg_we = 0;
    chk("R4 masked flags", {12'h0, flags}, 16'h0009);
    @(negedge clk); flg_we = 4'b1111; flg_val = 4'b1111;
    wr_en = 1; wr_wide = 1; wr_sel = 3; wr_grp = 3; wr_data = 16'h1200;
    @(posedge clk); #1 flg_we = 0; wr_en = 0;
    chk("R4 AF write wins", {12'h0, flags}, 16'h0000);
    @(negedge clk); flg_we = 4'b1010; flg_val = 4'b1111;
    @(posedge clk); #1 flg_we = 0;
    rd(1, 3, 3, d); chk("R4 Z and H only", d, 16'h12A0);
  endtask

  task automatic t_groups;
    logic [15:0] d;
    wr(1, 3, 1, 16'hFFFE);
    rd(1, 3, 1, d); chk("R5 SP grp1", d, 16'hFFFE);
    rd(1, 3, 0, d); chk("R5 SP grp0 alias", d, 16'hFFFE);
    wr(1, 0, 3, 16'hC0DE);
    rd(1, 0, 1, d); chk("R6 BC grp3 write", d, 16'hC0DE);
  endtask

  task automatic t_step_read;
    logic [15:0] d;
    wr(1, 2, 1, 16'hFFFF);
    rd(1, 2, 2, d); chk("R7 inc returns old", d, 16'hFFFF);
    rd(1, 2, 1, d); chk("R7 inc wraps", d, 16'h0000);
    rd(1, 3, 2, d); chk("R7 dec returns old", d, 16'h0000);
    rd(1, 2, 1, d); chk("R7 dec wraps", d, 16'hFFFF);
  endtask

  task automatic t_step_write;
    logic [15:0] d;
    wr(1, 2, 2, 16'h1234);
    rd(1, 2, 1, d); chk("R8 write inc", d, 16'h1235);
    wr(1, 3, 2, 16'h0000);
    rd(1, 2, 1, d); chk("R8 write dec wrap", d, 16'hFFFF);
  endtask

  task automatic t_conflict;
    logic [15:0] d;
    wr(1, 2, 1, 16'h10FF);
    @(negedge clk);
    rd_en = 1; rd_wide = 1; rd_sel = 2; rd_grp = 2;
    wr_en = 1; wr_wide = 0; wr_sel = 5; wr_data = 16'h0077;
    #1 chk("R9 read value", rd_data, 16'h10FF);
    @(posedge clk); #1 rd_en = 0; wr_en = 0;
    rd(1, 2, 1, d); chk("R9 L write wins", d, 16'h1077);
    @(negedge clk);
    rd_en = 1; rd_wide = 1; rd_sel = 2; rd_grp = 2;
    wr_en = 1; wr_wide = 1; wr_sel = 0; wr_grp = 1; wr_data = 16'h5555;
    @(posedge clk); #1 rd_en = 0; wr_en = 0;
    rd(1, 2, 1, d); chk("R9 step kept", d, 16'h1078);
    rd(1, 0, 1, d); chk("R9 BC written", d, 16'h5555);
  endtask

  task automatic t_mem;
    logic [15:0] d;
    wr(1, 2, 1, 16'h4321);
    @(negedge clk);
    mem_req_ready = 0; mem_rsp_valid = 0;
    rd_en = 1; rd_wide = 0; rd_sel = 6;
    #1;
    chk("R10 req valid", {15'h0, mem_req_valid}, 16'h0001);
    chk("R10 read dir", {15'h0, mem_req_write}, 16'h0000);
    chk("R10 addr", mem_req_addr, 16'h4321);
    chk("R10 wait", {15'h0, rd_valid}, 16'h0000);
    mem_req_ready = 1; mem_rsp_valid = 1; mem_rsp_data = 8'h5A;
    #1;
    chk("R10 done", {15'h0, rd_valid}, 16'h0001);
    chk("R10 data", rd_data, 16'h005A);
    @(posedge clk); #1 rd_en = 0; mem_req_ready = 0; mem_rsp_valid = 0;
    @(negedge clk);
    wr_en = 1; wr_wide = 0; wr_sel = 6; wr_data = 16'h0099;
    #1;
    chk("R11 write dir", {15'h0, mem_req_write}, 16'h0001);
    chk("R11 wdata", {8'h0, mem_req_wdata}, 16'h0099);
    chk("R11 stall", {15'h0, wr_ack}, 16'h0000);
    mem_req_ready = 1;
    #1 chk("R11 ack", {15'h0, wr_ack}, 16'h0001);
    @(posedge clk); #1 wr_en = 0; mem_req_ready = 0;
    rd(0, 7, 0, d); chk("R11 A untouched", d, 16'h0012);
    rd(1, 2, 1, d); chk("R11 HL untouched", d, 16'h4321);
    @(negedge clk);
    rd_en = 1; rd_wide = 0; rd_sel = 6;
    wr_en = 1; wr_wide = 0; wr_sel = 6; wr_data = 16'h0033;
    mem_req_ready = 1; mem_rsp_valid = 1;
    #1;
    chk("R12 write owns", {15'h0, mem_req_write}, 16'h0001);
    chk("R12 read blocked", {15'h0, rd_valid}, 16'h0000);
    chk("R12 write acked", {15'h0, wr_ack}, 16'h0001);
    @(posedge clk); #1 rd_en = 0; wr_en = 0; mem_req_ready = 0; mem_rsp_valid = 0;
  endtask

  task automatic t_pc;
    @(negedge clk); pc_we = 1; pc_wdata = 16'hBEEF;
    @(posedge clk); #1 pc_we = 0;
    chk("R13 pc load", pc, 16'hBEEF);
    @(posedge clk); #1 chk("R13 pc holds", pc, 16'hBEEF);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset;
    t_bytes;
    t_flags;
    t_groups;
    t_step_read;
    t_step_write;
    t_conflict;
    t_mem;
    t_pc;
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule